// File: doc/BRIEF.md
# Interrupt Entry and Return Stacking Sequencer

This block runs the interrupt entry and return sequences of a small 8-bit processor. Instruction decode and the ALU live elsewhere. The processor's register file reaches the block as parallel input ports, and the restored or updated values leave on parallel output ports. Stack traffic goes through a byte-wide memory port with one access per cycle. Reads are combinational: the data is valid in the same cycle as the address.

At each instruction boundary, signalled by `insn_done`, the block decides whether to take an interrupt. It looks at:
- a set of maskable requests, each gated by its own enable and by the global I mask;
- one non-maskable-style request, gated only by the X mask.

When it takes an interrupt, it pushes nine register bytes to descending addresses. After the condition-code byte is stored, it sets the mask bits. It then reads a 16-bit vector for the winning source and presents the new register file with a one-cycle `regs_load` strobe.

A boundary that carries `rti_req` instead pulls the nine bytes back in reverse order and restores the whole register file, including the stack pointer.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset, `busy`, `regs_load`, `mem_we` and `mem_re` are low, and the block stays idle until a boundary with a takeable request or a return request.
- R2: A maskable source k is takeable only when `irq_req[k]` and `irq_en[k]` are both set and I (CCR bit 4 of `ccr_in`) is clear. `xirq_req` is takeable whenever X (CCR bit 6) is clear, whatever I holds. With nothing takeable, a boundary starts no memory access.
- R3: A sequence starts only on a cycle where `insn_done` is high. Entry takes priority only when `rti_req` is low; a boundary with `rti_req` high starts the return sequence.
- R4: Entry writes nine bytes in nine consecutive cycles, to SP, SP-1, … SP-8. The bytes go in this order: PC low, PC high, IY low, IY high, IX low, IX high, A, B, CCR.
- R5: The stacked CCR byte is the CCR value held before entry. The CCR loaded at the end of entry has bit 4 set, and has bit 6 set as well when the non-maskable source was the one taken.
- R6: The vector is read high byte first, from the vector address, then the low byte from the next address, in two cycles. The non-maskable source uses `VEC_XIRQ`; maskable source k uses `VEC_BASE - 2*k`. The PC loaded at the end of entry is that 16-bit value.
- R7: The non-maskable source outranks every maskable source. Among maskable sources, a lower index wins.
- R8: The stack pointer moves by one for each byte. `sp_out` is SP-9 after entry and equals the original SP after a return from SP-9.
- R9: Return reads SP+1 through SP+9 in nine consecutive cycles. The bytes come back in reverse stacking order (CCR first, PC low last), and all six registers are restored from the bytes read.
- R10: `busy` is high for exactly 11 cycles on entry and 9 cycles on return. `regs_load` pulses for one cycle, on the cycle right after the last busy cycle, while `busy` is low.
- R11: Requests and `insn_done` that change during a sequence do not alter or restart it. The next boundary is then judged against the newly loaded mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary reached |
| rti_req | input | 1 | Return-from-interrupt requested at this boundary |
| irq_req | input | N_SRC | Maskable interrupt requests |
| irq_en | input | N_SRC | Per-source enables |
| xirq_req | input | 1 | Non-maskable-style request, gated by X |
| pc_in | input | 16 | Current program counter |
| ix_in | input | 16 | Current index register X |
| iy_in | input | 16 | Current index register Y |
| acc_a_in | input | 8 | Current accumulator A |
| acc_b_in | input | 8 | Current accumulator B |
| ccr_in | input | 8 | Current condition codes (bit 4 = I, bit 6 = X) |
| sp_in | input | 16 | Current stack pointer |
| mem_we | output | 1 | Stack byte write strobe |
| mem_re | output | 1 | Stack or vector byte read strobe |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte written |
| mem_rdata | input | 8 | Byte read (valid in the cycle of the address) |
| busy | output | 1 | Sequence in progress |
| regs_load | output | 1 | One-cycle strobe: register outputs are to be loaded |
| pc_out | output | 16 | Resulting program counter |
| ix_out | output | 16 | Resulting index X |
| iy_out | output | 16 | Resulting index Y |
| acc_a_out | output | 8 | Resulting accumulator A |
| acc_b_out | output | 8 | Resulting accumulator B |
| ccr_out | output | 8 | Resulting condition codes |
| sp_out | output | 16 | Resulting stack pointer |

## Verification
The first stack write shows up in the cycle after the clock edge that samples the boundary. The nine writes then come on consecutive cycles, followed by the two vector reads. `regs_load` therefore appears 12 cycles after the boundary edge on entry, and 10 cycles after it on return.

The bench drives inputs on falling edges and checks every one of those cycles, also on falling edges, against addresses, bytes and vectors it computes arithmetically. It sweeps every combination of request, enable, mask and non-maskable bits for four sources, and each taken entry is followed by the matching return. The boundary right after each entry is driven with the freshly loaded masks, and one cycle later the bench checks that nothing has started.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    localparam int AW       = 16;
    localparam int DW       = 8;
    localparam int N_BYTES  = 9;
    localparam int CW       = 4;
    localparam int I_POS    = 4;
    localparam int X_POS    = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_VEC,
        S_PULL,
        S_LOAD
    } seq_e;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] ix;
        logic [AW-1:0] iy;
        logic [DW-1:0] acc_a;
        logic [DW-1:0] acc_b;
        logic [DW-1:0] ccr;
    } regfile_t;

    typedef struct packed {
        seq_e          st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] sp;
        logic [AW-1:0] vec;
        logic          x_taken;
        regfile_t      rf;
    } ctl_t;

endpackage

// File: rtl/irqs_arbiter.sv
module irqs_arbiter #(
    parameter int          N_SRC    = 4,
    parameter logic [15:0] VEC_XIRQ = 16'hFFF4,
    parameter logic [15:0] VEC_BASE = 16'hFFF2
) (
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] irq_en,
    input  logic             xirq_req,
    input  logic             i_mask,
    input  logic             x_mask,
    output logic             take,
    output logic             x_win,
    output logic [15:0]      vec_addr
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0] live;
    logic [IW-1:0]    sel;
    logic             any_live;
    logic [15:0]      offset;

    for (genvar k = 0; k < N_SRC; k++) begin : g_gate
        assign live[k] = irq_req[k] & irq_en[k] & ~i_mask;
    end

    always_comb begin
        sel = '0;
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (live[k]) sel = IW'(k);
        end
    end

    assign any_live = |live;
    assign x_win    = xirq_req & ~x_mask;
    assign take     = x_win | any_live;
    assign offset   = 16'(sel) << 1;
    assign vec_addr = x_win ? VEC_XIRQ : (VEC_BASE - offset);

endmodule

// File: rtl/irqs_push_sel.sv
module irqs_push_sel
    import irqs_pkg::*;
(
    input  regfile_t       rf,
    input  logic [CW-1:0]  idx,
    output logic [DW-1:0]  byte_out
);
    always_comb begin
        case (idx)
            4'd0:    byte_out = rf.pc[7:0];
            4'd1:    byte_out = rf.pc[15:8];
            4'd2:    byte_out = rf.iy[7:0];
            4'd3:    byte_out = rf.iy[15:8];
            4'd4:    byte_out = rf.ix[7:0];
            4'd5:    byte_out = rf.ix[15:8];
            4'd6:    byte_out = rf.acc_a;
            4'd7:    byte_out = rf.acc_b;
            default: byte_out = rf.ccr;
        endcase
    end

endmodule

// File: rtl/irqs_pull_merge.sv
module irqs_pull_merge
    import irqs_pkg::*;
(
    input  regfile_t       rf_in,
    input  logic [CW-1:0]  idx,
    input  logic [DW-1:0]  data,
    output regfile_t       rf_out
);
    always_comb begin
        rf_out = rf_in;
        case (idx)
            4'd0:    rf_out.pc[7:0]   = data;
            4'd1:    rf_out.pc[15:8]  = data;
            4'd2:    rf_out.iy[7:0]   = data;
            4'd3:    rf_out.iy[15:8]  = data;
            4'd4:    rf_out.ix[7:0]   = data;
            4'd5:    rf_out.ix[15:8]  = data;
            4'd6:    rf_out.acc_a     = data;
            4'd7:    rf_out.acc_b     = data;
            default: rf_out.ccr       = data;
        endcase
    end

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irqs_pkg::*;
#(
    parameter int          N_SRC    = 4,
    parameter logic [15:0] VEC_XIRQ = 16'hFFF4,
    parameter logic [15:0] VEC_BASE = 16'hFFF2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             rti_req,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] irq_en,
    input  logic             xirq_req,
    input  logic [15:0]      pc_in,
    input  logic [15:0]      ix_in,
    input  logic [15:0]      iy_in,
    input  logic [7:0]       acc_a_in,
    input  logic [7:0]       acc_b_in,
    input  logic [7:0]       ccr_in,
    input  logic [15:0]      sp_in,
    output logic             mem_we,
    output logic             mem_re,
    output logic [15:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata,
    output logic             busy,
    output logic             regs_load,
    output logic [15:0]      pc_out,
    output logic [15:0]      ix_out,
    output logic [15:0]      iy_out,
    output logic [7:0]       acc_a_out,
    output logic [7:0]       acc_b_out,
    output logic [7:0]       ccr_out,
    output logic [15:0]      sp_out
);
    localparam logic [CW-1:0] LAST_IDX = CW'(N_BYTES - 1);

    ctl_t          ctl_d, ctl_q;
    logic          arb_take, arb_x;
    logic [15:0]   arb_vec;
    logic [DW-1:0] push_byte;
    logic [CW-1:0] pull_idx;
    regfile_t      merged_rf;
    regfile_t      in_rf;

    assign in_rf = '{pc: pc_in, ix: ix_in, iy: iy_in,
                     acc_a: acc_a_in, acc_b: acc_b_in, ccr: ccr_in};

    irqs_arbiter #(
        .N_SRC    (N_SRC),
        .VEC_XIRQ (VEC_XIRQ),
        .VEC_BASE (VEC_BASE)
    ) u_arb (
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .xirq_req (xirq_req),
        .i_mask   (ccr_in[I_POS]),
        .x_mask   (ccr_in[X_POS]),
        .take     (arb_take),
        .x_win    (arb_x),
        .vec_addr (arb_vec)
    );

    irqs_push_sel u_push (
        .rf       (ctl_q.rf),
        .idx      (ctl_q.cnt),
        .byte_out (push_byte)
    );

    // Pull step j restores the byte that push step (8 - j) stored
    assign pull_idx = LAST_IDX - ctl_q.cnt;

    irqs_pull_merge u_pull (
        .rf_in  (ctl_q.rf),
        .idx    (pull_idx),
        .data   (mem_rdata),
        .rf_out (merged_rf)
    );

    always_comb begin
        ctl_d     = ctl_q;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = ctl_q.sp;
        mem_wdata = push_byte;
        regs_load = 1'b0;
        busy      = 1'b0;

        case (ctl_q.st)
            S_IDLE: begin
                if (insn_done && rti_req) begin
                    ctl_d.st  = S_PULL;
                    ctl_d.cnt = '0;
                    ctl_d.sp  = sp_in;
                    ctl_d.rf  = in_rf;
                end else if (insn_done && arb_take) begin
                    ctl_d.st      = S_PUSH;
                    ctl_d.cnt     = '0;
                    ctl_d.sp      = sp_in;
                    ctl_d.rf      = in_rf;
                    ctl_d.vec     = arb_vec;
                    ctl_d.x_taken = arb_x;
                end
            end

            S_PUSH: begin
                busy     = 1'b1;
                mem_we   = 1'b1;
                mem_addr = ctl_q.sp;
                ctl_d.sp = ctl_q.sp - 16'd1;
                if (ctl_q.cnt == LAST_IDX) begin
                    // masks change only once the CCR byte is on the stack
                    ctl_d.rf.ccr[I_POS] = 1'b1;
                    if (ctl_q.x_taken) ctl_d.rf.ccr[X_POS] = 1'b1;
                    ctl_d.st  = S_VEC;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CW'(1);
                end
            end

            S_VEC: begin
                busy     = 1'b1;
                mem_re   = 1'b1;
                mem_addr = ctl_q.vec + 16'(ctl_q.cnt);
                if (ctl_q.cnt == '0) begin
                    ctl_d.rf.pc[15:8] = mem_rdata;
                    ctl_d.cnt         = CW'(1);
                end else begin
                    ctl_d.rf.pc[7:0] = mem_rdata;
                    ctl_d.st         = S_LOAD;
                    ctl_d.cnt        = '0;
                end
            end

            S_PULL: begin
                busy     = 1'b1;
                mem_re   = 1'b1;
                mem_addr = ctl_q.sp + 16'd1;
                ctl_d.sp = ctl_q.sp + 16'd1;
                ctl_d.rf = merged_rf;
                if (ctl_q.cnt == LAST_IDX) begin
                    ctl_d.st  = S_LOAD;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CW'(1);
                end
            end

            S_LOAD: begin
                regs_load = 1'b1;
                ctl_d.st  = S_IDLE;
            end

            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, cnt: '0, sp: '0, vec: '0,
                       x_taken: 1'b0, rf: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pc_out    = ctl_q.rf.pc;
    assign ix_out    = ctl_q.rf.ix;
    assign iy_out    = ctl_q.rf.iy;
    assign acc_a_out = ctl_q.rf.acc_a;
    assign acc_b_out = ctl_q.rf.acc_b;
    assign ccr_out   = ctl_q.rf.ccr;
    assign sp_out    = ctl_q.sp;

endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_done,
    input logic        busy,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr,
    input logic        regs_load,
    input logic [7:0]  ccr_out,
    input logic [15:0] sp_out
);
    // R1: no memory traffic while idle
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    p_one_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_start_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_done));

    p_push_descend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    p_read_ascend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 16'd1));

    p_load_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        regs_load |-> ($past(busy) && !busy));

    // Entry ends with write, read, read, then the load strobe
    p_imask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_load && $past(mem_re) && $past(mem_re, 2) && $past(mem_we, 3))
        |-> ccr_out[4]);

    p_sp_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_load && $past(mem_re) && $past(mem_re, 2) && $past(mem_we, 3))
        |-> (sp_out == $past(mem_addr, 3) - 16'd1));

endmodule

bind irq_stack_seq irq_stack_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .regs_load (regs_load),
    .ccr_out   (ccr_out),
    .sp_out    (sp_out)
);

// File: tb/test_irq_stack_seq.sv
module test_irq_stack_seq;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          insn_done = 1'b0, rti_req = 1'b0, xirq_req = 1'b0;
    logic [NS-1:0] irq_req = '0, irq_en = '0;
    logic [15:0]   pc_in = '0, ix_in = '0, iy_in = '0, sp_in = '0;
    logic [7:0]    acc_a_in = '0, acc_b_in = '0, ccr_in = '0;
    logic          mem_we, mem_re, busy, regs_load;
    logic [15:0]   mem_addr, pc_out, ix_out, iy_out, sp_out;
    logic [7:0]    mem_wdata, mem_rdata, acc_a_out, acc_b_out, ccr_out;
    logic [7:0]    bmem [256];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_stack_seq #(.N_SRC(NS)) i_irq_stack_seq (.*);

    assign mem_rdata = bmem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] vbyte(input logic [15:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    task automatic run_combo(input int c);
        logic [NS-1:0] req, en, live;
        logic ib, xr, xb, xt, mt, noise;
        logic [15:0] pc, ix, iy, sp, v;
        logic [7:0]  a, b, ccr, ccr_new;
        logic [7:0]  stk [9];
        int idx;
        req = c[3:0]; en = c[7:4]; ib = c[8]; xr = c[9]; xb = c[10];
        noise = c[3] ^ c[9];
        ccr = ((8'h21 + c[7:0]) & 8'hAF) | {1'b0, xb, 1'b0, ib, 4'b0};
        pc = 16'h4000 + 16'(c * 13);
        ix = 16'h8000 ^ 16'(c * 257);
        iy = 16'h2C00 + 16'(c * 3);
        a = c[7:0] ^ 8'h5A; b = ~c[7:0];
        sp = 16'h0180 + 16'((c % 3) * 16);
        live = ib ? '0 : (req & en);
        xt = xr & ~xb;
        mt = |live;
        idx = 0;
        for (int k = NS - 1; k >= 0; k--) if (live[k]) idx = k;
        v = xt ? 16'hFFF4 : 16'hFFF2 - 16'(2 * idx);
        ccr_new = ccr | 8'h10 | (xt ? 8'h40 : 8'h00);
        stk = '{pc[7:0], pc[15:8], iy[7:0], iy[15:8], ix[7:0], ix[15:8], a, b, ccr};

        @(negedge clk);
        irq_req = req; irq_en = en; xirq_req = xr;
        pc_in = pc; ix_in = ix; iy_in = iy; acc_a_in = a; acc_b_in = b;
        ccr_in = ccr; sp_in = sp; insn_done = 1'b1; rti_req = 1'b0;
        @(negedge clk);
        insn_done = noise;
        if (!(xt || mt)) begin
            chk("R2", "busy when masked", {31'b0, busy}, 0);
            chk("R2", "write when masked", {31'b0, mem_we}, 0);
            insn_done = 1'b0;
            return;
        end
        for (int k = 0; k < 9; k++) begin
            chk("R10", "busy push", {31'b0, busy}, 1);
            chk("R4", "push we", {31'b0, mem_we}, 1);
            chk("R4", "push addr", {16'b0, mem_addr}, {16'b0, sp - 16'(k)});
            chk(k == 8 ? "R5" : "R4", "push data", {24'b0, mem_wdata}, {24'b0, stk[k]});
            if (noise && k == 2) begin
                irq_req = '1; irq_en = '1; xirq_req = 1'b1; // R11 noise
                pc_in = 16'hDEAD; ccr_in = 8'h00;
            end
            @(negedge clk);
        end
        chk("R6", "vec hi re", {31'b0, mem_re}, 1);
        chk("R6", "vec hi addr", {16'b0, mem_addr}, {16'b0, v});
        @(negedge clk);
        chk("R6", "vec lo addr", {16'b0, mem_addr}, {16'b0, v + 16'd1});
        chk("R10", "busy vec", {31'b0, busy}, 1);
        @(negedge clk);
        chk("R10", "load strobe", {31'b0, regs_load}, 1);
        chk("R10", "busy at load", {31'b0, busy}, 0);
        chk("R7", "vector pc", {16'b0, pc_out}, {16'b0, vbyte(v), vbyte(v + 16'd1)});
        chk("R5", "ccr masks", {24'b0, ccr_out}, {24'b0, ccr_new});
        chk("R8", "sp entry", {16'b0, sp_out}, {16'b0, sp - 16'd9});
        chk("R11", "regs kept", {ix_out, iy_out}, {ix, iy});
        // R11: next boundary judged with the new masks
        irq_req = req; irq_en = en; xirq_req = xr; ccr_in = ccr_new; insn_done = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11", "retake after masks", {30'b0, busy, mem_we}, 0);
        insn_done = 1'b0;
        // R9: return from SP-9 with garbage on the inputs
        @(negedge clk);
        sp_in = sp - 16'd9; pc_in = 16'h0BAD; ix_in = 16'h1111; iy_in = 16'h2222;
        acc_a_in = 8'h33; acc_b_in = 8'h44; rti_req = 1'b1; insn_done = 1'b1;
        @(negedge clk);
        rti_req = 1'b0; insn_done = 1'b0;
        for (int j = 0; j < 9; j++) begin
            chk("R9", "pull re", {31'b0, mem_re}, 1);
            chk("R9", "pull addr", {16'b0, mem_addr}, {16'b0, sp - 16'd8 + 16'(j)});
            @(negedge clk);
        end
        chk("R10", "return load", {31'b0, regs_load}, 1);
        chk("R9", "restored pc", {16'b0, pc_out}, {16'b0, pc});
        chk("R9", "restored ix iy", {ix_out, iy_out}, {ix, iy});
        chk("R9", "restored a b ccr", {8'b0, acc_a_out, acc_b_out, ccr_out}, {8'b0, a, b, ccr});
        chk("R8", "sp return", {16'b0, sp_out}, {16'b0, sp});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'h3C;
        repeat (3) @(negedge clk);
        chk("R1", "reset busy", {31'b0, busy}, 0);
        chk("R1", "reset strobes", {29'b0, mem_we, mem_re, regs_load}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", {30'b0, busy, mem_we}, 0);
        // R3: requests without a boundary start nothing
        irq_req = '1; irq_en = '1; xirq_req = 1'b1; ccr_in = 8'h00;
        repeat (3) @(negedge clk);
        chk("R3", "no boundary", {30'b0, busy, mem_we}, 0);
        irq_req = '0; irq_en = '0; xirq_req = 1'b0;
        for (int c = 0; c < 2048; c++) run_combo(c);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule